// File: doc/BRIEF.md
# MSI Doorbell Shared-Interrupt Register Bank

This block collects message-signalled interrupt doorbell writes and turns each one into a pending bit in one of several shared status words. Every status word drives its own level interrupt toward an interrupt controller. A service routine reads a status word to learn which sources fired, and that read acknowledges them. The doorbell data word carries two fields. Its low `SEL_W` bits pick the status word. The bits above them give a source number. Sources are filled from the most significant bit of a word downward.

The block has two build-time layouts. In the full layout each status word carries 32 sources, so there are `32 << SEL_W` valid doorbell values. In the packed layout each word carries 8 sources in its own byte lane. Word k owns bits 31-8k down to 24-8k, so the layout is built with `SEL_W` = 2. Read data is presented big-endian: bit 31 of a word leaves on `rd_data[7:0]` and bit 0 on `rd_data[31:24]`. A doorbell whose source number is out of range leaves no pending bit. Instead it sets a sticky error flag, which can be read back and is cleared by that read.

Top module: `msi_doorbell_bank`

## Requirements
- R1: In the full layout (`COMPACT`=0), a write with `wr_en` at `wr_addr` 0 takes s = `wr_data[SEL_W-1:0]` and n = `wr_data >> SEL_W`. When n < 32 it sets bit 31-n of status word s.
- R2: In the packed layout (`COMPACT`=1), the same doorbell with n < 8 sets bit 31-8s-n of status word s.
- R3: A doorbell with n at or above the source count (32 full, 8 packed) changes no status bit. It sets the error flag, which is read at byte address 0x40 as `rd_data` bit 24 (word bit 0 after the lane swap). That read clears the flag.
- R4: Status word k is read at byte address 0x4+4k in the full layout and at 0x10+4k in the packed layout. Read data appears on `rd_data` in the cycle after `rd_en`, and `rd_data` is zero in any cycle that follows no read.
- R5: Read data is byte-swapped: word bits 31:24 appear on `rd_data[7:0]`, and word bits 7:0 appear on `rd_data[31:24]`.
- R6: A read of a status word or of the error flag clears exactly the bits it returns. A doorbell that sets a bit in the same cycle is kept and shows on the next read.
- R7: `irq[k]` is high exactly while status word k has any bit set. It rises in the cycle after the doorbell and falls in the cycle after the read that clears the word.
- R8: A read of `wr_addr`/`rd_addr` 0, or of any address that is unmapped or not word-aligned, returns zero. A write with `wr_addr` other than 0 changes nothing.
- R9: While `rst_n` is low at a clock edge, all status bits and the error flag clear, `irq` drops to zero and `rd_data` becomes zero. Doorbells are ignored during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address; 0 is the doorbell |
| wr_data | input | 32 | Doorbell word: select field low, source number above it |
| rd_en | input | 1 | Read strobe; also acknowledges what is returned |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered, byte-swapped read data |
| irq | output | 1<<SEL_W | Level interrupt per status word |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:

- A doorbell shows up on `irq` at the next edge.
- A read places its data on `rd_data` and clears the returned bits at that same edge, so the lowered `irq` and the data are visible together.

The bench drives the inputs on the falling edge. It then advances a behavioural model at the rising edge, using those same inputs, and compares both layouts at the next falling edge. In this way each comparison lands on the cycle in which the block is due to answer.

// File: rtl/msi_bank_pkg.sv
// Package: shared constants and helpers for the MSI doorbell bank.
// Assumes 32-bit status words and a byte-addressed register bus.
package msi_bank_pkg;
    localparam int WORD_W      = 32;
    localparam int LANE_W      = 8;
    localparam int FULL_SRC    = 32;
    localparam int PACKED_SRC  = 8;
    localparam int FULL_BASE   = 4;
    localparam int PACKED_BASE = 16;
    localparam int ERR_OFS     = 64;

    // Reverse byte order so that word bit 31 leaves on the lowest byte lane.
    function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction
endpackage

// File: rtl/msi_doorbell_decode.sv
// Module: splits a doorbell word into a status-word select and a source
// number, and produces per-word set masks plus an out-of-range pulse.
// Assumes that the packed layout is built with SEL_W = 2 (four byte lanes).
module msi_doorbell_decode
    import msi_bank_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter bit COMPACT = 1'b0,
    parameter int ADDR_W  = 8
) (
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [WORD_W-1:0]             wr_data,
    output logic [(1<<SEL_W)-1:0][WORD_W-1:0] set_mask,
    output logic                          bad_src
);
    localparam int NREG = 1 << SEL_W;
    localparam int NW   = WORD_W - SEL_W;
    localparam int SRC  = COMPACT ? PACKED_SRC : FULL_SRC;

    logic [SEL_W-1:0] sel;
    logic [NW-1:0]    num;
    logic             hit;
    logic             in_range;
    logic [4:0]       pos;

    assign sel      = wr_data[SEL_W-1:0];
    assign num      = wr_data[WORD_W-1:SEL_W];
    assign hit      = wr_en && (wr_addr == '0);
    assign in_range = (num < NW'(SRC));
    assign bad_src  = hit && !in_range;

    // Bit position: 31 minus the source offset, written as a bit inversion.
    generate
        if (COMPACT) begin : g_packed
            assign pos = ~{sel[1:0], num[2:0]};
        end else begin : g_full
            assign pos = ~num[4:0];
        end
    endgenerate

    // One set mask per status word; only the selected word sees a bit.
    always_comb begin
        for (int k = 0; k < NREG; k++) begin
            set_mask[k] = (hit && in_range && (sel == SEL_W'(k)))
                        ? (WORD_W'(1) << pos) : '0;
        end
    end
endmodule

// File: rtl/msi_status_word.sv
// Module: one shared status word. It sets bits from a mask and clears the
// whole word on an acknowledging read. Set wins over clear in the same cycle.
// Assumes the clear strobe is raised only when this word's value is returned.
module msi_status_word
    import msi_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] set_bits,
    input  logic              clr,
    output logic [WORD_W-1:0] value,
    output logic              pending
);
    // Pending-bit storage with read-clear and concurrent set.
    always_ff @(posedge clk) begin
        if (!rst_n) value <= '0;
        else        value <= (clr ? '0 : value) | set_bits;
    end

    // Level interrupt: any bit held.
    assign pending = |value;
endmodule

// File: rtl/msi_read_port.sv
// Module: read address decode, acknowledge strobes and the registered,
// byte-swapped read data. Unmapped or unaligned reads return zero.
module msi_read_port
    import msi_bank_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter bit COMPACT = 1'b0,
    parameter int ADDR_W  = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rd_en,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic [(1<<SEL_W)-1:0][WORD_W-1:0] status,
    input  logic                              err_flag,
    output logic [(1<<SEL_W)-1:0]             clr_word,
    output logic                              clr_err,
    output logic [WORD_W-1:0]                 rd_data
);
    localparam int NREG = 1 << SEL_W;
    localparam int BASE = COMPACT ? PACKED_BASE : FULL_BASE;

    logic [WORD_W-1:0] sel_val;

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_hit
            localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BASE + 4*k);
            // Acknowledge strobe for status word k.
            assign clr_word[k] = rd_en && (rd_addr == OFS);
        end
    endgenerate

    assign clr_err = rd_en && (rd_addr == ADDR_W'(ERR_OFS));

    // Merge the addressed source into one word.
    always_comb begin
        sel_val = clr_err ? {{(WORD_W-1){1'b0}}, err_flag} : '0;
        for (int k = 0; k < NREG; k++) begin
            if (clr_word[k]) sel_val = sel_val | status[k];
        end
    end

    // Register the lane-swapped result; zero when nothing is read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= lane_swap(sel_val);
    end
endmodule

// File: rtl/msi_doorbell_bank.sv
// Module: top of the MSI doorbell bank. It decodes doorbell writes into
// status words, raises one level interrupt per word, and serves read-clear
// accesses. Assumes single-cycle strobes and a synchronous active-low reset.
module msi_doorbell_bank
    import msi_bank_pkg::*;
#(
    parameter int SEL_W   = 3,
    parameter bit COMPACT = 1'b0,
    parameter int ADDR_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [31:0]             wr_data,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [31:0]             rd_data,
    output logic [(1<<SEL_W)-1:0]   irq
);
    localparam int NREG = 1 << SEL_W;

    logic [NREG-1:0][WORD_W-1:0] set_mask;
    logic [NREG-1:0][WORD_W-1:0] status;
    logic [NREG-1:0]             clr_word;
    logic                        bad_src;
    logic                        clr_err;
    logic                        err_flag;

    msi_doorbell_decode #(.SEL_W(SEL_W), .COMPACT(COMPACT), .ADDR_W(ADDR_W)) u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .set_mask (set_mask),
        .bad_src  (bad_src)
    );

    generate
        for (genvar k = 0; k < NREG; k++) begin : g_word
            msi_status_word u_word (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_bits (set_mask[k]),
                .clr      (clr_word[k]),
                .value    (status[k]),
                .pending  (irq[k])
            );
        end
    endgenerate

    // Sticky error flag: set by an out-of-range doorbell, cleared by its read.
    always_ff @(posedge clk) begin
        if (!rst_n) err_flag <= 1'b0;
        else        err_flag <= (clr_err ? 1'b0 : err_flag) | bad_src;
    end

    msi_read_port #(.SEL_W(SEL_W), .COMPACT(COMPACT), .ADDR_W(ADDR_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .status   (status),
        .err_flag (err_flag),
        .clr_word (clr_word),
        .clr_err  (clr_err),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/msi_doorbell_bank_chk.sv
// Module: port-level checker for the MSI doorbell bank, bound to every
// instance of the top module.
module msi_doorbell_bank_chk #(
    parameter int SEL_W   = 3,
    parameter bit COMPACT = 1'b0,
    parameter int ADDR_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [31:0]           wr_data,
    input logic                  rd_en,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [31:0]           rd_data,
    input logic [(1<<SEL_W)-1:0] irq
);
    localparam int SRC = COMPACT ? 8 : 32;

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (irq == '0 && rd_data == '0));

    assert_doorbell_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == '0) |=> (rd_data == '0));

    assert_unaligned_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr[1:0] != 2'b00) |=> (rd_data == '0));

    assert_idle_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));

    assert_irq_rise_needs_doorbell_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq & ~$past(irq)) != '0) |-> $past(wr_en && wr_addr == '0));

    assert_irq_fall_needs_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~irq & $past(irq)) != '0) |-> $past(rd_en));

    assert_bad_source_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0 && (wr_data >> SEL_W) >= 32'(SRC))
        |=> ((irq & ~$past(irq)) == '0));
endmodule

bind msi_doorbell_bank msi_doorbell_bank_chk #(
    .SEL_W(SEL_W), .COMPACT(COMPACT), .ADDR_W(ADDR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq(irq)
);

// File: tb/tb_msi_doorbell_bank.sv
// Bench: drives a full-layout instance (SEL_W=3) and a packed-layout
// instance (SEL_W=2) with the same bus traffic. A behavioural model of both
// is advanced every clock, and every output is compared on every clock.
module tb_msi_doorbell_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data_f, rd_data_p;
    logic [7:0]  irq_f;
    logic [3:0]  irq_p;

    int compared = 0;
    int mismatched = 0;
    string tag = "R9";

    logic [31:0] m_st [2][8];
    logic        m_err [2];
    logic [31:0] m_rd [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_doorbell_bank #(.SEL_W(3), .COMPACT(1'b0), .ADDR_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_f), .irq(irq_f));

    msi_doorbell_bank #(.SEL_W(2), .COMPACT(1'b1), .ADDR_W(8)) dut_c (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data_p), .irq(irq_p));

    // Model of one rising edge for both layouts, from the requirement text.
    task automatic model_edge();
        for (int c = 0; c < 2; c++) begin
            int nreg = c ? 4 : 8;
            int sw   = c ? 2 : 3;
            int base = c ? 16 : 4;
            int src  = c ? 8 : 32;
            logic [31:0] r = '0;
            if (!rst_n) begin
                for (int k = 0; k < 8; k++) m_st[c][k] = '0;
                m_err[c] = 1'b0;
                m_rd[c]  = '0;
            end else begin
                if (rd_en) begin
                    for (int k = 0; k < nreg; k++) begin
                        if (int'(rd_addr) == base + 4*k) begin
                            r = m_st[c][k];
                            m_st[c][k] = '0;
                        end
                    end
                    if (int'(rd_addr) == 64) begin
                        r = {31'b0, m_err[c]};
                        m_err[c] = 1'b0;
                    end
                end
                m_rd[c] = {<<8{r}};
                if (wr_en && wr_addr == 8'd0) begin
                    int s = int'(wr_data) & (nreg - 1);
                    longint n = longint'(wr_data) >> sw;
                    if (n < src) begin
                        int p = c ? (31 - 8*s - int'(n)) : (31 - int'(n));
                        m_st[c][s][p] = 1'b1;
                    end else begin
                        m_err[c] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic cmp32(string what, logic [31:0] act, logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge.
    task automatic step(logic w, logic [7:0] wa, logic [31:0] wd, logic r, logic [7:0] ra);
        logic [7:0] ef;
        logic [3:0] ep;
        wr_en = w; wr_addr = wa; wr_data = wd; rd_en = r; rd_addr = ra;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        for (int k = 0; k < 8; k++) ef[k] = (m_st[0][k] != '0);
        for (int k = 0; k < 4; k++) ep[k] = (m_st[1][k] != '0);
        cmp32("full rd_data", rd_data_f, m_rd[0]);
        cmp32("packed rd_data", rd_data_p, m_rd[1]);
        cmp32("full irq", {24'b0, irq_f}, {24'b0, ef});
        cmp32("packed irq", {28'b0, irq_p}, {28'b0, ep});
    endtask

    task automatic db(logic [31:0] d);  step(1'b1, 8'd0, d, 1'b0, 8'd0); endtask
    task automatic rd(logic [7:0] a);   step(1'b0, 8'd0, '0, 1'b1, a);   endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        // R9: reset state, with a doorbell offered during reset
        tag = "R9";
        step(1'b0, 8'd0, '0, 1'b0, 8'd0);
        step(1'b1, 8'd0, 32'd0, 1'b0, 8'd0);
        step(1'b0, 8'd0, '0, 1'b1, 8'd4);
        rst_n = 1'b1;
        rd(8'd4);
        // R1: full layout source placement, both ends of the source range
        tag = "R1";
        db(32'd0);
        db((32'd31 << 3) | 32'd5);
        db((32'd9 << 3) | 32'd2);
        for (int k = 0; k < 8; k++) rd(8'(4 + 4*k));
        // R2: packed lanes, every word at lane top and lane bottom
        tag = "R2";
        for (int s = 0; s < 4; s++) begin
            db(32'(s));
            db(32'((7 << 2) | s));
        end
        for (int k = 0; k < 4; k++) rd(8'(16 + 4*k));
        // R3: out-of-range sources and the sticky error flag
        tag = "R3";
        db(32'd32 << 3);
        db(32'hFFFF_FFFF);
        db(32'd8 << 2);
        rd(8'd64);
        rd(8'd64);
        // R5: lane swap of a mixed pattern
        tag = "R5";
        db(32'd0); db(32'd7 << 3); db(32'd24 << 3); db(32'd31 << 3);
        rd(8'd4); rd(8'd16);
        // R6: doorbell landing on the word being read in the same cycle
        tag = "R6";
        db(32'd1 << 3);
        step(1'b1, 8'd0, 32'd2 << 3, 1'b1, 8'd4);
        rd(8'd4);
        step(1'b1, 8'd0, 32'd40 << 3, 1'b1, 8'd64);
        rd(8'd64);
        // R8: writes off the doorbell, reads of unmapped addresses
        tag = "R8";
        step(1'b1, 8'd4, 32'd0, 1'b0, 8'd0);
        step(1'b1, 8'd16, 32'd3, 1'b1, 8'd0);
        db(32'd4);
        rd(8'd5); rd(8'd200); rd(8'd0);
        rd(8'd20); rd(8'd4);
        // R4, R7: mixed traffic over the whole address map
        tag = "R4/R7";
        for (int i = 0; i < 400; i++) begin
            logic [7:0] ra = 8'($urandom_range(0, 17) * 4);
            logic [7:0] wa = ($urandom_range(0, 7) == 0) ? 8'd8 : 8'd0;
            step($urandom_range(0, 1) == 1, wa, 32'($urandom_range(0, 330)),
                 $urandom_range(0, 2) == 0, ra);
        end
        for (int k = 0; k < 17; k++) rd(8'(4*k));
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule